// File: doc/BRIEF.md
# Recursive Cross-Product Unsigned Multiplier

This block multiplies two unsigned operands of `W` bits each (8 by default) and returns the full `2W`-bit product in one combinational pass. It is built by recursion. Each level of `W` bits splits both operands into low and high halves. It forms the four half-width cross products with four copies of the next level down, and the recursion ends at a 2x2 gate cell.

At each level, a row of `W` full adders folds the two middle cross products into the overlapping bits of the outer ones. A carry-skip adder of `3W/2-1` bits then resolves the remaining sum and carry vectors. The low `W/2` product bits come straight from the low-by-low sub-product and are never added.

Two enables surround the core. The first forces the operands seen by the core to zero while it is low. The second forces the product port to zero while it is low. The same source builds the 16-bit and 32-bit versions through the width parameter.

Top module: `vm_mul`

## Requirements
- R1: With both enables high, `prod_o` equals the unsigned product `opa_i * opb_i` for every pair of 8-bit operands at the default width.
- R2: With `W` set to 16 or 32 and both enables high, `prod_o` equals the unsigned `2W`-bit product of the operands.
- R3: With `mul_en_i` low and `out_en_i` high, the core receives zero operands, so `prod_o` is zero whatever the operands are.
- R4: With `out_en_i` low, `prod_o` is zero for any operands and either state of `mul_en_i`.
- R5: Product bits `[W/2-1:0]` equal the low `W/2` bits of the product of the operands' low halves.
- R6: Each level's final adder is a carry-skip adder with 4-bit groups, and its sum equals a plain ripple addition for all inputs. Operands that drive long propagate chains, such as all ones or alternating bit patterns, still give exact products.
- R7: The block holds no state. `prod_o` follows an operand or enable change without any clock edge.
- R8: When an enable returns high, the product of the operands present at that moment appears at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mul_en_i | input | 1 | Operand enable; when low the core sees zeros |
| out_en_i | input | 1 | Output enable; when low the product port is zero |
| opa_i | input | W | Multiplicand, unsigned |
| opb_i | input | W | Multiplier, unsigned |
| prod_o | output | 2W | Unsigned product |

## Verification
The 8-bit build is tried with every one of the 65536 operand pairs. This shows that the recursion's alignment and each reduction bit are correct everywhere, not only for typical values. In the same cycles, the 16-bit and 32-bit builds receive random pairs, which separates width-dependent slicing faults from faults in the shared structure. Directed patterns add all ones, alternating bits and single high bits; these drive the skip path through full propagate runs, where a wrong bypass would corrupt the carry. Enable sweeps with nonzero operands distinguish input gating from output gating and confirm that a product reappears as soon as the enables return high.

// File: rtl/vm_pkg.sv
package vm_pkg;
  localparam int unsigned SKIP_GROUP = 4;

  function automatic bit is_pow2(input int unsigned v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/vm_cell2.sv
module vm_cell2 (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  output logic [3:0] p_o
);
  logic x01, x10, c1;

  assign x01 = a_i[0] & b_i[1];
  assign x10 = a_i[1] & b_i[0];
  assign c1  = x01 & x10;

  assign p_o[0] = a_i[0] & b_i[0];
  assign p_o[1] = x01 ^ x10;
  assign p_o[2] = (a_i[1] & b_i[1]) ^ c1;
  assign p_o[3] = a_i[1] & b_i[1] & c1;

  always_comb begin
    // R1
    cell_prod_chk: assert (p_o == {2'b00, a_i} * {2'b00, b_i})
      else $error("2x2 cell product mismatch");
  end
endmodule

// File: rtl/vm_skip_adder.sv
module vm_skip_adder #(
  parameter int unsigned W = 11,
  parameter int unsigned G = vm_pkg::SKIP_GROUP
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned NG = (W + G - 1) / G;
  localparam int unsigned PW = NG * G;

  logic [PW-1:0] a_pad, b_pad;

  assign a_pad = {{(PW-W){1'b0}}, a_i};
  assign b_pad = {{(PW-W){1'b0}}, b_i};

  always_comb begin
    logic c, c_grp, prop, ai, bi;
    int   idx;
    sum_o  = '0;
    cout_o = 1'b0;
    c      = cin_i;
    for (int g = 0; g < int'(NG); g++) begin
      c_grp = c;
      prop  = 1'b1;
      for (int j = 0; j < int'(G); j++) begin
        idx  = g * int'(G) + j;
        ai   = a_pad[idx];
        bi   = b_pad[idx];
        prop = prop & (ai ^ bi);
        if (idx < int'(W)) sum_o[idx] = ai ^ bi ^ c;
        c = (ai & bi) | (c & (ai ^ bi));
        if (idx == int'(W) - 1) cout_o = c;
      end
      // group bypass: incoming carry skips a fully propagating group
      if (prop) begin
        c = c_grp;
        if ((g + 1) * int'(G) >= int'(W)) cout_o = c_grp;
      end
    end
  end

  always_comb begin
    // R6
    skip_sum_chk: assert ({cout_o, sum_o} == {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i})
      else $error("carry-skip sum differs from ripple sum");
  end
endmodule

// File: rtl/vm_level.sv
module vm_level #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned H = W / 2;
  localparam int unsigned K = 3 * H - 1;

  if (W == 2) begin : g_base
    vm_cell2 u_cell (.a_i(a_i), .b_i(b_i), .p_o(p_o));
  end else begin : g_split
    logic [W-1:0]   p_ll, p_lh, p_hl, p_hh;
    logic [W+H-1:0] outer;
    logic [W-1:0]   fa_s, fa_c;
    logic [K-1:0]   add_a, add_b, add_s;
    logic           add_co;

    vm_level #(.W(H)) u_ll (.a_i(a_i[H-1:0]), .b_i(b_i[H-1:0]), .p_o(p_ll));
    vm_level #(.W(H)) u_lh (.a_i(a_i[H-1:0]), .b_i(b_i[W-1:H]), .p_o(p_lh));
    vm_level #(.W(H)) u_hl (.a_i(a_i[W-1:H]), .b_i(b_i[H-1:0]), .p_o(p_hl));
    vm_level #(.W(H)) u_hh (.a_i(a_i[W-1:H]), .b_i(b_i[W-1:H]), .p_o(p_hh));

    // outer products concatenated, aligned to weight H
    assign outer = {p_hh, p_ll[W-1:H]};

    // first reduction row: W full adders
    for (genvar i = 0; i < int'(W); i++) begin : g_fa
      assign fa_s[i] = outer[i] ^ p_lh[i] ^ p_hl[i];
      assign fa_c[i] = (outer[i] & p_lh[i]) | (outer[i] & p_hl[i]) | (p_lh[i] & p_hl[i]);
    end

    assign add_a = {outer[W+H-1:W], fa_s[W-1:1]};
    assign add_b = {{(H-1){1'b0}}, fa_c};

    vm_skip_adder #(.W(K)) u_add (
      .a_i   (add_a),
      .b_i   (add_b),
      .cin_i (1'b0),
      .sum_o (add_s),
      .cout_o(add_co)
    );

    assign p_o = {add_s, fa_s[0], p_ll[H-1:0]};

    always_comb begin
      // R1
      no_overflow_chk: assert (!add_co)
        else $error("final adder carried out of product width");
      // R2
      level_prod_chk: assert (p_o == {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i})
        else $error("level product mismatch");
    end
  end
endmodule

// File: rtl/vm_mul.sv
module vm_mul #(
  parameter int unsigned W = 8
) (
  input  logic           mul_en_i,
  input  logic           out_en_i,
  input  logic [W-1:0]   opa_i,
  input  logic [W-1:0]   opb_i,
  output logic [2*W-1:0] prod_o
);
  localparam int unsigned PW = 2 * W;

  if (!vm_pkg::is_pow2(W)) begin : g_bad_w
    $error("W must be a power of two, at least 2");
  end

  logic [W-1:0]  core_a, core_b;
  logic [PW-1:0] core_p;

  assign core_a = mul_en_i ? opa_i : '0;
  assign core_b = mul_en_i ? opb_i : '0;

  vm_level #(.W(W)) u_core (.a_i(core_a), .b_i(core_b), .p_o(core_p));

  assign prod_o = out_en_i ? core_p : '0;

  always_comb begin
    // R3
    in_gate_chk: assert (mul_en_i || prod_o == '0)
      else $error("product nonzero with operand enable low");
    // R1
    top_prod_chk: assert (!(mul_en_i && out_en_i) || prod_o == {{W{1'b0}}, opa_i} * {{W{1'b0}}, opb_i})
      else $error("enabled product mismatch");
  end
endmodule

// File: tb/vm_mul_test.sv
module vm_mul_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        men, oen;
  logic [7:0]  a8, b8;
  logic [15:0] p8;
  logic [15:0] a16, b16;
  logic [31:0] p16;
  logic [31:0] a32, b32;
  logic [63:0] p32;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  vm_mul #(.W(8))  uut   (.mul_en_i(men), .out_en_i(oen), .opa_i(a8),  .opb_i(b8),  .prod_o(p8));
  vm_mul #(.W(16)) uut16 (.mul_en_i(men), .out_en_i(oen), .opa_i(a16), .opb_i(b16), .prod_o(p16));
  vm_mul #(.W(32)) uut32 (.mul_en_i(men), .out_en_i(oen), .opa_i(a32), .opb_i(b32), .prod_o(p32));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
    longint unsigned xl = longint'(x);
    longint unsigned yl = longint'(y);
    return xl * yl;
  endfunction

  task automatic drive8(input logic [7:0] x, input logic [7:0] y, input logic me, input logic oe);
    @(posedge clk);
    a8 = x; b8 = y; men = me; oen = oe;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    men = 0; oen = 0; a8 = 8'hA5; b8 = 8'h3C; a16 = 16'h1234; b16 = 16'hFFFF;
    a32 = 32'hDEADBEEF; b32 = 32'h12345678;
    repeat (3) @(negedge clk);
    // reset-time state: enables low, outputs zero (R4)
    chk("R4 reset p8", 64'(p8), 64'h0);
    chk("R4 reset p32", p32, 64'h0);
    rst_ni = 1'b1;

    // R1 exhaustive 8-bit, R2 random 16/32, R5 low-half bits
    for (int i = 0; i < 65536; i++) begin
      @(posedge clk);
      men = 1; oen = 1;
      a8 = i[15:8]; b8 = i[7:0];
      a16 = 16'($urandom); b16 = 16'($urandom);
      a32 = $urandom; b32 = $urandom;
      @(negedge clk);
      chk("R1 exhaustive", 64'(p8), ref_mul(32'(a8), 32'(b8)));
      chk("R5 low half", 64'(p8[3:0]), ref_mul(32'(a8[3:0]), 32'(b8[3:0])) & 64'hF);
      chk("R2 w16", 64'(p16), ref_mul(32'(a16), 32'(b16)));
      chk("R2 w32", p32, ref_mul(a32, b32));
    end

    // R6 long propagate chains
    begin
      logic [31:0] pat [6] = '{32'hFFFFFFFF, 32'h55555555, 32'hAAAAAAAA,
                               32'h80000000, 32'h7FFFFFFF, 32'h00000001};
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          @(posedge clk);
          a8 = pat[i][7:0]; b8 = pat[j][7:0];
          a16 = pat[i][15:0]; b16 = pat[j][15:0];
          a32 = pat[i]; b32 = pat[j];
          @(negedge clk);
          chk("R6 p8", 64'(p8), ref_mul(32'(a8), 32'(b8)));
          chk("R6 p16", 64'(p16), ref_mul(32'(a16), 32'(b16)));
          chk("R6 p32", p32, ref_mul(a32, b32));
        end
      end
    end

    // R3 operand enable low
    drive8(8'hFF, 8'hFF, 1'b0, 1'b1);
    chk("R3 p8", 64'(p8), 64'h0);
    chk("R3 p32", p32, 64'h0);
    drive8(8'h9C, 8'h71, 1'b0, 1'b1);
    chk("R3 p8 b", 64'(p8), 64'h0);

    // R4 output enable low, both operand-enable states
    drive8(8'hFF, 8'hFE, 1'b1, 1'b0);
    chk("R4 men1", 64'(p8), 64'h0);
    chk("R4 men1 p16", 64'(p16), 64'h0);
    drive8(8'hC3, 8'h5A, 1'b0, 1'b0);
    chk("R4 men0", 64'(p8), 64'h0);

    // R8 re-enable restores product at once
    drive8(8'hC3, 8'h5A, 1'b1, 1'b1);
    chk("R8 reenable", 64'(p8), ref_mul(32'hC3, 32'h5A));

    // R7 mid-cycle change with no clock edge
    @(posedge clk);
    #1;
    a8 = 8'hEE; b8 = 8'hD7;
    #1;
    chk("R7 comb a", 64'(p8), ref_mul(32'hEE, 32'hD7));
    oen = 0;
    #1;
    chk("R7 comb oen", 64'(p8), 64'h0);
    oen = 1; men = 0;
    #1;
    chk("R7 comb men", 64'(p8), 64'h0);
    men = 1;
    #1;
    chk("R8 comb men", 64'(p8), ref_mul(32'hEE, 32'hD7));

    done = 1;
    summary();
    $finish;
  end
endmodule